// File: doc/BRIEF.md
# Modem Line Auto-Enable Controller

This block manages the modem handshake lines of one serial channel. It receives the active-low clear-to-send and carrier-detect lines and drives the active-low request-to-send line. A single auto-enable bit chooses how the lines behave. When the bit is set, clear-to-send gates the transmitter enable and carrier-detect gates the receiver enable. When the bit is clear, the lines are plain general-purpose status inputs and request-to-send is a plain output.

Both input lines pass through a two-stage synchronizer. A status latch watches the synchronized levels. When an enabled line changes, the latch freezes both levels and holds an external/status interrupt request. The request stays until software issues a reset-status command. A change that occurs while the latch is frozen is reported after that reset.

The request-to-send controller has three states. `RTS_IDLE` drives the line high. `RTS_ACTIVE` drives it low. `RTS_DRAIN` keeps it low after the control bit has been cleared, while asynchronous auto-enable operation waits for the transmitter to empty. The transitions are:
- idle to active when the control bit is set;
- active to idle when the bit clears and either the drain rule is off or the transmitter is empty;
- active to drain when the bit clears with the drain rule on and the transmitter still busy;
- drain to idle when the transmitter empties;
- drain to active when the bit is set again.

The status latch has two states. `LAT_TRACK` follows the lines. `LAT_HELD` is frozen with an interrupt pending. The transitions are:
- track to held when an enabled line differs from its stored level;
- held to track on the reset-status command.

Top module: `modem_ctl_top`

## Requirements
- R1: After reset, `rts_n_o` is 1, `irq_o` is 0, `cts_stat_o` and `dcd_stat_o` are 0, and both enables are 0 while the lines are high.
- R2: With `cfg_auto_en_i`=1, `tx_en_o` equals `cfg_tx_en_i` AND (clear-to-send low). A pin change reaches `tx_en_o` on the second clock edge after it, not the first.
- R3: With `cfg_auto_en_i`=1, `rx_en_o` equals `cfg_rx_en_i` AND (carrier-detect low), with the same two-edge latency.
- R4: With `cfg_auto_en_i`=0, `tx_en_o` equals `cfg_tx_en_i` and `rx_en_o` equals `cfg_rx_en_i` whatever the line levels. While no interrupt is pending, `cts_stat_o` and `dcd_stat_o` read 1 when their line is low.
- R5: A falling or a rising change on a line whose enable bit (`cfg_cts_ie_i`, `cfg_dcd_ie_i`) is 1 sets the pending request. `irq_o` is pending AND `cfg_ext_ie_i`.
- R6: A change on a line whose enable bit is 0 sets no pending request.
- R7: While a request is pending, `cts_stat_o` and `dcd_stat_o` hold the levels latched at the change. A one-cycle `rst_stat_i` pulse clears the request. If an enabled line differs from its latched level at that point, a new request is raised that carries the new level.
- R8: Unless both `cfg_auto_en_i` and `cfg_async_i` are 1, `rts_n_o` is the inverse of `cfg_rts_i`, registered: it changes one clock edge after `cfg_rts_i` changes.
- R9: With `cfg_auto_en_i`=1 and `cfg_async_i`=1, clearing `cfg_rts_i` leaves `rts_n_o` at 0 until `tx_empty_i` is 1. `rts_n_o` goes to 1 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send line, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier-detect line, active low, asynchronous |
| cfg_auto_en_i | input | 1 | Auto-enable mode bit |
| cfg_async_i | input | 1 | Channel is in asynchronous mode |
| cfg_rts_i | input | 1 | Request-to-send control bit |
| cfg_tx_en_i | input | 1 | Software transmitter enable |
| cfg_rx_en_i | input | 1 | Software receiver enable |
| cfg_cts_ie_i | input | 1 | Clear-to-send change interrupt enable |
| cfg_dcd_ie_i | input | 1 | Carrier-detect change interrupt enable |
| cfg_ext_ie_i | input | 1 | Global external/status interrupt enable |
| rst_stat_i | input | 1 | Reset-status command pulse |
| tx_empty_i | input | 1 | Transmitter fully drained |
| rts_n_o | output | 1 | Request-to-send line, active low |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| cts_stat_o | output | 1 | Clear-to-send asserted (1 = line low), latched while pending |
| dcd_stat_o | output | 1 | Carrier-detect asserted (1 = line low), latched while pending |
| irq_o | output | 1 | External/status interrupt request |

## Verification
The gating is driven with each line held high, then low, with auto-enable on and off. This separates real gating from pass-through. It also samples one edge after a pin change, which tells a missing synchronizer stage from a correct one.

Interrupt tests cover:
- a falling change and a rising change on an enabled line;
- a change on a masked line;
- a change made while the global enable is off;
- a change made while the latch is frozen, which must be reported only after reset-status.

Request-to-send is cleared with the transmitter busy in three setups: plain mode, auto-enable in synchronous mode, and auto-enable in asynchronous mode. Only the last must hold the line low until the transmitter is empty.

// File: rtl/modem_pkg.sv
package modem_pkg;

    localparam int unsigned LINE_CNT = 2;
    localparam int unsigned LINE_CTS = 0;
    localparam int unsigned LINE_DCD = 1;

    typedef enum logic [1:0] {
        RTS_IDLE   = 2'd0,
        RTS_ACTIVE = 2'd1,
        RTS_DRAIN  = 2'd2
    } rts_state_t;

    typedef enum logic {
        LAT_TRACK = 1'b0,
        LAT_HELD  = 1'b1
    } lat_state_t;

endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic        IDLE   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= {WIDTH{IDLE}};
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= {WIDTH{IDLE}};
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/modem_stat_latch.sv
module modem_stat_latch
    import modem_pkg::*;
#(
    parameter int unsigned WIDTH = LINE_CNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_n_i,
    input  logic [WIDTH-1:0] ie_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] ref_n_o,
    output logic             pend_o
);

    lat_state_t       state_q, state_d;
    logic [WIDTH-1:0] ref_q, ref_d;
    logic [WIDTH-1:0] diff;
    logic             event_hit;

    always_comb begin
        diff      = (lvl_n_i ^ ref_q) & ie_i;
        event_hit = |diff;
    end

    always_comb begin
        state_d = state_q;
        ref_d   = ref_q;
        unique case (state_q)
            LAT_TRACK: begin
                ref_d = lvl_n_i;
                if (event_hit) state_d = LAT_HELD;
            end
            LAT_HELD: begin
                if (clr_i) state_d = LAT_TRACK;
            end
            default: state_d = LAT_TRACK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LAT_TRACK;
            ref_q   <= {WIDTH{1'b1}};
        end else begin
            state_q <= state_d;
            ref_q   <= ref_d;
        end
    end

    always_comb begin
        ref_n_o = ref_q;
        pend_o  = (state_q == LAT_HELD);
    end

endmodule

// File: rtl/modem_rts_fsm.sv
module modem_rts_fsm
    import modem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic drain_mode_i,
    input  logic tx_empty_i,
    output logic rts_n_o
);

    rts_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_IDLE: begin
                if (req_i) state_d = RTS_ACTIVE;
            end
            RTS_ACTIVE: begin
                if (!req_i) begin
                    if (drain_mode_i && !tx_empty_i) state_d = RTS_DRAIN;
                    else                             state_d = RTS_IDLE;
                end
            end
            RTS_DRAIN: begin
                if (req_i)           state_d = RTS_ACTIVE;
                else if (tx_empty_i) state_d = RTS_IDLE;
            end
            default: state_d = RTS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rts_n_o = (state_q == RTS_IDLE);
    end

endmodule

// File: rtl/modem_ctl_top.sv
module modem_ctl_top
    import modem_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_i,
    input  logic dcd_n_i,
    input  logic cfg_auto_en_i,
    input  logic cfg_async_i,
    input  logic cfg_rts_i,
    input  logic cfg_tx_en_i,
    input  logic cfg_rx_en_i,
    input  logic cfg_cts_ie_i,
    input  logic cfg_dcd_ie_i,
    input  logic cfg_ext_ie_i,
    input  logic rst_stat_i,
    input  logic tx_empty_i,
    output logic rts_n_o,
    output logic tx_en_o,
    output logic rx_en_o,
    output logic cts_stat_o,
    output logic dcd_stat_o,
    output logic irq_o
);

    logic [LINE_CNT-1:0] line_raw_n;
    logic [LINE_CNT-1:0] line_sync_n;
    logic [LINE_CNT-1:0] line_ie;
    logic [LINE_CNT-1:0] line_ref_n;
    logic                stat_pend;
    logic                drain_mode;

    assign line_raw_n[LINE_CTS] = cts_n_i;
    assign line_raw_n[LINE_DCD] = dcd_n_i;
    assign line_ie[LINE_CTS]    = cfg_cts_ie_i;
    assign line_ie[LINE_DCD]    = cfg_dcd_ie_i;

    modem_sync #(
        .WIDTH (LINE_CNT),
        .STAGES(SYNC_STAGES),
        .IDLE  (1'b1)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(line_raw_n),
        .sync_o (line_sync_n)
    );

    modem_stat_latch #(
        .WIDTH(LINE_CNT)
    ) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_n_i(line_sync_n),
        .ie_i   (line_ie),
        .clr_i  (rst_stat_i),
        .ref_n_o(line_ref_n),
        .pend_o (stat_pend)
    );

    assign drain_mode = cfg_auto_en_i & cfg_async_i;

    modem_rts_fsm rts_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (cfg_rts_i),
        .drain_mode_i(drain_mode),
        .tx_empty_i  (tx_empty_i),
        .rts_n_o     (rts_n_o)
    );

    always_comb begin
        tx_en_o    = cfg_tx_en_i & (~cfg_auto_en_i | ~line_sync_n[LINE_CTS]);
        rx_en_o    = cfg_rx_en_i & (~cfg_auto_en_i | ~line_sync_n[LINE_DCD]);
        cts_stat_o = ~line_ref_n[LINE_CTS];
        dcd_stat_o = ~line_ref_n[LINE_DCD];
        irq_o      = stat_pend & cfg_ext_ie_i;
    end

endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic cts_n_i,
    input logic dcd_n_i,
    input logic cfg_auto_en_i,
    input logic cfg_async_i,
    input logic cfg_ext_ie_i,
    input logic rst_stat_i,
    input logic tx_empty_i,
    input logic rts_n_o,
    input logic tx_en_o,
    input logic rx_en_o,
    input logic cts_stat_o,
    input logic dcd_stat_o,
    input logic irq_o,
    input logic pend
);

    // R1: reset leaves the line inactive and no request
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (rts_n_o && !irq_o));

    // R2: clear-to-send high two edges ago blocks the transmitter in auto mode
    a_r2_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_en_i && $past(cts_n_i, 2)) |-> !tx_en_o);

    // R3: carrier-detect high two edges ago blocks the receiver in auto mode
    a_r3_dcd_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_auto_en_i && $past(dcd_n_i, 2)) |-> !rx_en_o);

    // R7: latched levels frozen while pending
    a_r7_stat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !rst_stat_i) |=> ($stable(cts_stat_o) && $stable(dcd_stat_o)));

    // R7: pending request persists until reset-status
    a_r7_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !rst_stat_i) |=> pend);

    // R5: interrupt output only with a pending request
    a_r5_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend && cfg_ext_ie_i));

    // R9: line stays asserted while draining a busy transmitter
    a_r9_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rts_n_o && cfg_auto_en_i && cfg_async_i && !tx_empty_i) |=> !rts_n_o);

endmodule

bind modem_ctl_top modem_ctl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cts_n_i      (cts_n_i),
    .dcd_n_i      (dcd_n_i),
    .cfg_auto_en_i(cfg_auto_en_i),
    .cfg_async_i  (cfg_async_i),
    .cfg_ext_ie_i (cfg_ext_ie_i),
    .rst_stat_i   (rst_stat_i),
    .tx_empty_i   (tx_empty_i),
    .rts_n_o      (rts_n_o),
    .tx_en_o      (tx_en_o),
    .rx_en_o      (rx_en_o),
    .cts_stat_o   (cts_stat_o),
    .dcd_stat_o   (dcd_stat_o),
    .irq_o        (irq_o),
    .pend         (stat_pend)
);

// File: tb/modem_ctl_tb.sv
module modem_ctl_top_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cts_n_i = 1'b1, dcd_n_i = 1'b1;
    logic cfg_auto_en_i = 1'b0, cfg_async_i = 1'b0, cfg_rts_i = 1'b0;
    logic cfg_tx_en_i = 1'b0, cfg_rx_en_i = 1'b0;
    logic cfg_cts_ie_i = 1'b0, cfg_dcd_ie_i = 1'b0, cfg_ext_ie_i = 1'b0;
    logic rst_stat_i = 1'b0, tx_empty_i = 1'b1;
    logic rts_n_o, tx_en_o, rx_en_o, cts_stat_o, dcd_stat_o, irq_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    modem_ctl_top dut_i (
        .clk(clk), .rst_n(rst_n), .cts_n_i(cts_n_i), .dcd_n_i(dcd_n_i),
        .cfg_auto_en_i(cfg_auto_en_i), .cfg_async_i(cfg_async_i),
        .cfg_rts_i(cfg_rts_i), .cfg_tx_en_i(cfg_tx_en_i), .cfg_rx_en_i(cfg_rx_en_i),
        .cfg_cts_ie_i(cfg_cts_ie_i), .cfg_dcd_ie_i(cfg_dcd_ie_i),
        .cfg_ext_ie_i(cfg_ext_ie_i), .rst_stat_i(rst_stat_i), .tx_empty_i(tx_empty_i),
        .rts_n_o(rts_n_o), .tx_en_o(tx_en_o), .rx_en_o(rx_en_o),
        .cts_stat_o(cts_stat_o), .dcd_stat_o(dcd_stat_o), .irq_o(irq_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic pulse_rst_stat();
        rst_stat_i = 1'b1;
        step(1);
        rst_stat_i = 1'b0;
    endtask

    task automatic t_reset();
        check(rts_n_o, 1'b1, "R1 rts_n after reset");
        check(irq_o, 1'b0, "R1 irq after reset");
        check(cts_stat_o, 1'b0, "R1 cts_stat after reset");
        check(dcd_stat_o, 1'b0, "R1 dcd_stat after reset");
        check(tx_en_o, 1'b0, "R1 tx_en after reset");
    endtask

    task automatic t_auto_gate();
        cfg_auto_en_i = 1'b1; cfg_tx_en_i = 1'b1; cfg_rx_en_i = 1'b1;
        step(3);
        check(tx_en_o, 1'b0, "R2 tx held off by cts high");
        check(rx_en_o, 1'b0, "R3 rx held off by dcd high");
        cts_n_i = 1'b0;
        step(1);
        check(tx_en_o, 1'b0, "R2 tx not yet after one edge");
        step(1);
        check(tx_en_o, 1'b1, "R2 tx enabled after two edges");
        check(rx_en_o, 1'b0, "R3 rx still off");
        dcd_n_i = 1'b0;
        step(2);
        check(rx_en_o, 1'b1, "R3 rx enabled by dcd low");
        cfg_tx_en_i = 1'b0;
        step(1);
        check(tx_en_o, 1'b0, "R2 tx follows software bit");
        cfg_tx_en_i = 1'b1;
        cts_n_i = 1'b1; dcd_n_i = 1'b1;
        step(3);
        check(tx_en_o, 1'b0, "R2 tx off after cts high");
        check(rx_en_o, 1'b0, "R3 rx off after dcd high");
    endtask

    task automatic t_plain_gate();
        cfg_auto_en_i = 1'b0;
        step(1);
        check(tx_en_o, 1'b1, "R4 tx pass-through with cts high");
        check(rx_en_o, 1'b1, "R4 rx pass-through with dcd high");
        dcd_n_i = 1'b0;
        step(4);
        check(dcd_stat_o, 1'b1, "R4 dcd level readable");
        check(cts_stat_o, 1'b0, "R4 cts level readable");
        dcd_n_i = 1'b1;
        cfg_tx_en_i = 1'b0; cfg_rx_en_i = 1'b0;
        step(4);
        check(tx_en_o, 1'b0, "R4 tx follows bit");
        check(dcd_stat_o, 1'b0, "R4 dcd level back high");
    endtask

    task automatic t_irq();
        cfg_cts_ie_i = 1'b1; cfg_dcd_ie_i = 1'b0; cfg_ext_ie_i = 1'b1;
        dcd_n_i = 1'b0;
        step(4);
        check(irq_o, 1'b0, "R6 masked dcd change ignored");
        check(dcd_stat_o, 1'b1, "R6 masked dcd still readable");
        cts_n_i = 1'b0;
        step(4);
        check(irq_o, 1'b1, "R5 falling cts raises irq");
        check(cts_stat_o, 1'b1, "R7 latched cts asserted");
        cts_n_i = 1'b1; dcd_n_i = 1'b1;
        step(4);
        check(irq_o, 1'b1, "R7 irq held without reset");
        check(cts_stat_o, 1'b1, "R7 cts status frozen");
        check(dcd_stat_o, 1'b1, "R7 dcd status frozen");
        pulse_rst_stat();
        step(2);
        check(irq_o, 1'b1, "R7 change during hold reported after reset");
        check(cts_stat_o, 1'b0, "R7 new cts level latched");
        pulse_rst_stat();
        step(3);
        check(irq_o, 1'b0, "R7 reset clears irq");
        cfg_ext_ie_i = 1'b0;
        cts_n_i = 1'b0;
        step(4);
        check(irq_o, 1'b0, "R5 global enable off masks irq");
        cfg_ext_ie_i = 1'b1;
        step(1);
        check(irq_o, 1'b1, "R5 pending shown when global enabled");
        pulse_rst_stat();
        step(2);
        check(irq_o, 1'b0, "R5 cleared after reset-status");
        cts_n_i = 1'b1;
        step(4);
        check(irq_o, 1'b1, "R5 rising cts raises irq");
        pulse_rst_stat();
        step(2);
        cfg_cts_ie_i = 1'b0;
    endtask

    task automatic t_rts();
        cfg_auto_en_i = 1'b0; cfg_async_i = 1'b1; tx_empty_i = 1'b0;
        cfg_rts_i = 1'b1;
        step(1);
        check(rts_n_o, 1'b0, "R8 rts asserts one edge after bit");
        cfg_rts_i = 1'b0;
        step(1);
        check(rts_n_o, 1'b1, "R8 rts releases with tx busy, plain mode");
        cfg_auto_en_i = 1'b1; cfg_async_i = 1'b0;
        cfg_rts_i = 1'b1;
        step(1);
        cfg_rts_i = 1'b0;
        step(1);
        check(rts_n_o, 1'b1, "R8 sync auto mode releases at once");
        cfg_async_i = 1'b1;
        cfg_rts_i = 1'b1;
        step(1);
        cfg_rts_i = 1'b0;
        step(5);
        check(rts_n_o, 1'b0, "R9 rts held while tx busy");
        tx_empty_i = 1'b1;
        step(1);
        check(rts_n_o, 1'b1, "R9 rts released when tx empty");
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_auto_gate();
        t_plain_gate();
        t_irq();
        t_rts();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule